// File: doc/BRIEF.md
# RTC periodic interrupt generator

This block produces the active-low periodic interrupt line of a real-time clock. A 3-bit mode input chooses one of eight behaviours. The line can be parked high or forced low. It can run as a 50% duty square wave at 2 Hz or 1 Hz, derived from the 32.768 kHz tick and phase-locked to the seconds counter. It can also latch low on one calendar event: each second, each minute, each hour or each month. The timekeeping counters supply that event as a one-cycle strobe.

In the latched modes the line stays low until software pulses the flag-clear input. If an event arrives on the same clock as a clear, the event wins. Changing the mode drops any pending flag. The new mode governs the output from the clock edge at which it is first sampled. The mode is registered inside the block, so a synchronous reset returns it to the parked-high state.

Top module: `rtc_pirq_top`

## Requirements
- R1: While `rst` is high at a rising edge, the registered mode becomes 000, the flag and the wave phase clear, and `irqN` reads 1 after that edge.
- R2: With mode 000 (`modeSel` = 3'b000) registered, `irqN` stays 1 whatever the event strobes, the tick or the clear do.
- R3: With mode 001 registered, `irqN` stays 0.
- R4: With mode 010 registered, `irqN` is a square wave whose half period is TICKS_PER_SEC/4 tick-enable cycles. It is low in the first half after a seconds increment.
- R5: With mode 011 registered, `irqN` is a square wave with a half period of TICKS_PER_SEC/2 tick-enable cycles. It is also low in the first half after a seconds increment.
- R6: A `secInc` strobe sampled at an edge restarts the half-period count and makes the wave phase low after that edge. If the count reaches the end of a half period, the phase toggles and the count restarts. The wave is visible on `irqN` in modes 010 and 011.
- R7: In the level modes the event source is fixed by the mode: 100 takes `secInc`, 101 takes `minRoll`, 110 takes `hourRoll` and 111 takes `monthRoll`. Strobes that do not belong to the registered mode leave `irqN` unchanged.
- R8: In a level mode, the selected event drives `irqN` low after the edge at which it is sampled. The line then stays low until a `flagClr` strobe is sampled. If the event and the clear are sampled on the same edge, `irqN` stays low.
- R9: If `modeSel` differs from the registered mode at an edge, the pending flag is dropped at that edge. The new mode drives `irqN` after the edge, so a change into a level mode reads 1 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tickEn | input | 1 | One-cycle enable at the 32.768 kHz rate |
| modeSel | input | 3 | Interrupt mode select |
| secInc | input | 1 | Seconds counter increment strobe |
| minRoll | input | 1 | Strobe when seconds reach 00 |
| hourRoll | input | 1 | Strobe at 00 minutes 00 seconds |
| monthRoll | input | 1 | Strobe at 00:00:00 on day 1 |
| flagClr | input | 1 | Software flag-clear strobe |
| irqN | output | 1 | Active-low interrupt output |

## Verification
The bench builds the block with TICKS_PER_SEC set to 16, so a half period lasts 4 ticks at 2 Hz and 8 ticks at 1 Hz. At that size many full wave cycles fit into a few hundred clocks, along with realignment in the middle of a half period. Ticks arrive either on every cycle or sparsely. With this scaling the bench can also reach a mode switch from 1 Hz to 2 Hz while the count lies past the shorter half-period limit. The default of 32768 changes only the count limits and the counter width.

// File: rtl/rtc_pirq_pkg.sv
package rtc_pirq_pkg;

  typedef enum logic [2:0] {
    MODE_OFF    = 3'b000,
    MODE_LOW    = 3'b001,
    MODE_WAVE2  = 3'b010,
    MODE_WAVE1  = 3'b011,
    MODE_LSEC   = 3'b100,
    MODE_LMIN   = 3'b101,
    MODE_LHOUR  = 3'b110,
    MODE_LMONTH = 3'b111
  } pirqMode_t;

  typedef enum logic [1:0] {
    OUT_HIGH = 2'd0,
    OUT_LOW  = 2'd1,
    OUT_WAVE = 2'd2,
    OUT_FLAG = 2'd3
  } pirqOut_t;

  // strobes from control to datapath
  typedef struct packed {
    pirqOut_t outSel;
    logic     setFlag;
    logic     clrFlag;
    logic     dropFlag;
    logic     realign;
    logic     fastHalf;
  } pirqStrobes_t;

endpackage

// File: rtl/rtc_pirq_ctrl.sv
module rtc_pirq_ctrl
  import rtc_pirq_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   modeSel,
  input  logic         secInc,
  input  logic         minRoll,
  input  logic         hourRoll,
  input  logic         monthRoll,
  input  logic         flagClr,
  output pirqMode_t    modeCur,
  output pirqStrobes_t strb
);

  pirqMode_t modeReg;
  logic      modeChg;
  logic [3:0] levelEvents;
  logic      isLevel;
  logic      eventHit;

  always_ff @(posedge clk) begin
    if (rst) modeReg <= MODE_OFF;
    else     modeReg <= pirqMode_t'(modeSel);
  end

  assign modeCur     = modeReg;
  assign modeChg     = (modeSel != modeReg);
  assign levelEvents = {monthRoll, hourRoll, minRoll, secInc};
  assign isLevel     = modeReg[2];
  assign eventHit    = levelEvents[modeReg[1:0]];

  always_comb begin
    strb          = '0;
    strb.setFlag  = isLevel && eventHit && !modeChg;
    strb.clrFlag  = flagClr;
    strb.dropFlag = modeChg;
    strb.realign  = secInc;
    strb.fastHalf = (modeReg == MODE_WAVE2);
    unique case (modeReg)
      MODE_OFF:               strb.outSel = OUT_HIGH;
      MODE_LOW:               strb.outSel = OUT_LOW;
      MODE_WAVE2, MODE_WAVE1: strb.outSel = OUT_WAVE;
      default:                strb.outSel = OUT_FLAG;
    endcase
  end

  // R7: an event that does not belong to the current level mode never sets the flag
  a_r7_source_match: assert property (@(posedge clk) disable iff (rst)
    (strb.setFlag) |-> (isLevel && levelEvents[modeReg[1:0]]));

endmodule

// File: rtl/rtc_pirq_datapath.sv
module rtc_pirq_datapath
  import rtc_pirq_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
)(
  input  logic         clk,
  input  logic         rst,
  input  logic         tickEn,
  input  pirqStrobes_t strb,
  output logic         irqN
);

  localparam int HALF_SLOW = TICKS_PER_SEC / 2;
  localparam int HALF_FAST = TICKS_PER_SEC / 4;
  localparam int CNT_W     = $clog2(HALF_SLOW);
  localparam logic [CNT_W-1:0] LAST_SLOW = CNT_W'(HALF_SLOW - 1);
  localparam logic [CNT_W-1:0] LAST_FAST = CNT_W'(HALF_FAST - 1);

  logic [CNT_W-1:0] tickCnt;
  logic             phaseLow;
  logic             flagSet;
  logic [CNT_W-1:0] lastCnt;

  assign lastCnt = strb.fastHalf ? LAST_FAST : LAST_SLOW;

  // half-period counter, realigned by the seconds increment
  always_ff @(posedge clk) begin
    if (rst) begin
      tickCnt  <= '0;
      phaseLow <= 1'b0;
    end else if (strb.realign) begin
      tickCnt  <= '0;
      phaseLow <= 1'b1;
    end else if (tickEn) begin
      if (tickCnt >= lastCnt) begin
        tickCnt  <= '0;
        phaseLow <= !phaseLow;
      end else begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end

  // level-mode flag: mode change, then event, then clear
  always_ff @(posedge clk) begin
    if (rst)               flagSet <= 1'b0;
    else if (strb.dropFlag) flagSet <= 1'b0;
    else if (strb.setFlag)  flagSet <= 1'b1;
    else if (strb.clrFlag)  flagSet <= 1'b0;
  end

  always_comb begin
    unique case (strb.outSel)
      OUT_HIGH: irqN = 1'b1;
      OUT_LOW:  irqN = 1'b0;
      OUT_WAVE: irqN = !phaseLow;
      default:  irqN = !flagSet;
    endcase
  end

  // R8: asserted level output holds until a clear or a mode change
  a_r8_hold_low: assert property (@(posedge clk) disable iff (rst)
    (strb.outSel == OUT_FLAG && !irqN && !strb.clrFlag && !strb.dropFlag) |=> !irqN);

  // R8: event wins over a clear on the same edge
  a_r8_event_wins: assert property (@(posedge clk) disable iff (rst)
    strb.setFlag |=> !irqN);

  // R9: entering a level mode starts with the line released
  a_r9_change_drops: assert property (@(posedge clk) disable iff (rst)
    strb.dropFlag |=> (strb.outSel != OUT_FLAG || irqN));

  // R6: seconds increment pulls the wave low at once
  a_r6_realign_low: assert property (@(posedge clk) disable iff (rst)
    (strb.realign && !strb.dropFlag && strb.outSel == OUT_WAVE) |=> !irqN);

endmodule

// File: rtl/rtc_pirq_top.sv
module rtc_pirq_top
  import rtc_pirq_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
)(
  input  logic       clk,
  input  logic       rst,
  input  logic       tickEn,
  input  logic [2:0] modeSel,
  input  logic       secInc,
  input  logic       minRoll,
  input  logic       hourRoll,
  input  logic       monthRoll,
  input  logic       flagClr,
  output logic       irqN
);

  pirqStrobes_t strb;
  pirqMode_t    modeCur;

  rtc_pirq_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .modeSel   (modeSel),
    .secInc    (secInc),
    .minRoll   (minRoll),
    .hourRoll  (hourRoll),
    .monthRoll (monthRoll),
    .flagClr   (flagClr),
    .modeCur   (modeCur),
    .strb      (strb)
  );

  rtc_pirq_datapath #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .tickEn (tickEn),
    .strb   (strb),
    .irqN   (irqN)
  );

  // R1: reset releases the line
  a_r1_reset_high: assert property (@(posedge clk) rst |=> irqN);

  // R2: parked mode stays high
  a_r2_parked_high: assert property (@(posedge clk) disable iff (rst)
    (modeCur == MODE_OFF && modeSel == 3'b000) |=> irqN);

  // R3: forced mode stays low
  a_r3_forced_low: assert property (@(posedge clk) disable iff (rst)
    (modeCur == MODE_LOW && modeSel == 3'b001) |=> !irqN);

endmodule

// File: tb/rtc_pirq_top_test.sv
`timescale 1ns/1ps
module rtc_pirq_top_test;

  localparam int TPS = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tickEn = 1'b0;
  logic [2:0] modeSel = 3'b000;
  logic secInc = 1'b0, minRoll = 1'b0, hourRoll = 1'b0, monthRoll = 1'b0, flagClr = 1'b0;
  logic irqN;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // stimulus controls
  bit tickDense = 1'b1;
  int secPeriod = 0;
  int secPhase = 0;
  int randLevel = 0;

  // reference model state
  int mMode = 0;
  int mFlag = 0;
  int mCnt = 0;
  int mPhase = 0;

  always #10 clk = !clk;

  rtc_pirq_top #(.TICKS_PER_SEC(TPS)) uut (
    .clk(clk), .rst(rst), .tickEn(tickEn), .modeSel(modeSel),
    .secInc(secInc), .minRoll(minRoll), .hourRoll(hourRoll),
    .monthRoll(monthRoll), .flagClr(flagClr), .irqN(irqN)
  );

  function automatic logic expOut();
    case (mMode)
      0: return 1'b1;
      1: return 1'b0;
      2, 3: return (mPhase == 0);
      default: return (mFlag == 0);
    endcase
  endfunction

  function automatic string modeTag();
    case (mMode)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s irqN actual=%b expected=%b at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  // reference model: behavioural, updated from the inputs sampled at each edge
  always @(posedge clk) begin
    int half;
    int ev;
    cycles++;
    if (rst) begin
      mMode = 0; mFlag = 0; mCnt = 0; mPhase = 0;
    end else begin
      half = (mMode == 2) ? TPS / 4 : TPS / 2;
      if (secInc) begin
        mCnt = 0; mPhase = 1;
      end else if (tickEn) begin
        if (mCnt >= half - 1) begin mCnt = 0; mPhase = 1 - mPhase; end
        else mCnt++;
      end
      case (mMode)
        4: ev = secInc;
        5: ev = minRoll;
        6: ev = hourRoll;
        7: ev = monthRoll;
        default: ev = 0;
      endcase
      if (int'(modeSel) != mMode) mFlag = 0;
      else if (ev != 0) mFlag = 1;
      else if (flagClr) mFlag = 0;
      mMode = int'(modeSel);
    end
  end

  // compare on every clock, away from the edge
  always @(negedge clk) begin
    if (cycles > 0) chk(rst ? "R1" : modeTag(), irqN, expOut());
  end

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      finishRun();
    end
  end

  // advance one clock; one-shot strobes set by the caller last one edge
  task automatic step();
    @(posedge clk);
    #5;
    minRoll = 0; hourRoll = 0; monthRoll = 0; flagClr = 0; secInc = 0;
    tickEn = tickDense ? 1'b1 : (($urandom % 3) == 0);
    if (secPeriod > 0) begin
      secPhase++;
      if (secPhase >= secPeriod) begin secPhase = 0; secInc = 1; end
    end
    if (randLevel > 0) begin
      minRoll   = (($urandom % randLevel) == 0);
      hourRoll  = (($urandom % randLevel) == 0);
      monthRoll = (($urandom % randLevel) == 0);
      flagClr   = (($urandom % randLevel) == 0);
      if (secPeriod == 0) secInc = (($urandom % randLevel) == 0);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    // R1: reset state
    run(3);
    chk("R1", irqN, 1'b1);
    rst = 0;

    // R2: parked, events ignored
    randLevel = 3; secPeriod = 0;
    run(40);
    chk("R2", irqN, 1'b1);

    // R3: forced low
    modeSel = 3'b001;
    run(30);
    chk("R3", irqN, 1'b0);

    // R4: 2 Hz wave, dense ticks, second every 16 cycles
    randLevel = 0; secPeriod = TPS; tickDense = 1;
    modeSel = 3'b010;
    run(70);
    // R6: realign in the middle of a half period
    secPeriod = 0;
    run(6);
    step(); secInc = 1;
    step();
    chk("R6", irqN, 1'b0);
    run(30);

    // R5: 1 Hz wave, sparse ticks
    tickDense = 0; secPeriod = 40;
    modeSel = 3'b011;
    run(150);
    // switch to 2 Hz late in a slow half period
    tickDense = 1; secPeriod = 0;
    run(6);
    modeSel = 3'b010;
    run(20);

    // level modes with random events and clears
    tickDense = 1; secPeriod = 0; randLevel = 4;
    for (int m = 4; m < 8; m++) begin
      modeSel = 3'(m);
      run(60);
    end
    randLevel = 0;

    // R7: minute mode ignores the seconds strobe
    modeSel = 3'b101;
    run(2);
    step(); flagClr = 1;
    step(); secInc = 1; hourRoll = 1; monthRoll = 1;
    step();
    chk("R7", irqN, 1'b1);
    minRoll = 1;
    step();
    chk("R7", irqN, 1'b0);

    // R8: held until clear; event with clear keeps it low
    run(5);
    chk("R8", irqN, 1'b0);
    modeSel = 3'b110;
    step();
    chk("R9", irqN, 1'b1);
    hourRoll = 1; flagClr = 1;
    step();
    chk("R8", irqN, 1'b0);
    flagClr = 1;
    step();
    chk("R8", irqN, 1'b1);

    // R9: pending flag dropped on mode change
    modeSel = 3'b111;
    step(); monthRoll = 1;
    step();
    chk("R8", irqN, 1'b0);
    modeSel = 3'b100;
    step();
    chk("R9", irqN, 1'b1);

    // R1: reset in the middle of a wave
    modeSel = 3'b010; secPeriod = TPS;
    run(25);
    rst = 1;
    step();
    chk("R1", irqN, 1'b1);
    rst = 0; modeSel = 3'b000;
    run(10);

    finishRun();
  end

endmodule